// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Mapper

This block is the mapping logic of a cartridge for an 8-bit console. It watches the CPU side of the cartridge connector: CPU A14, the data bus, R/W and the active-low ROM select. It also watches the byte that the program ROM is driving. An 8-bit bank register is built from three fields. The low five bits choose the 16 KB program bank that appears in the lower program window. The next two bits choose one of four 8 KB CHR RAM banks. The top bit is the nametable page used when the single-screen arrangement is strapped. The upper program window always shows the last bank. Inside the block this is done by forcing the five program address lines high whenever CPU A14 is set.

A board strap selects one of two wiring modes. In the locked mode the ROM is always output-enabled and can never be written. Any CPU write to the cartridge space loads the bank register. Because the ROM drives the bus during such a write, the stored value is the CPU byte ANDed with the ROM byte. In the programmable mode the write space is split in two. Writes with A14 high load the bank register. Writes with A14 low pull the flash write-enable low so that program-and-erase command sequences reach the flash. In this mode the ROM output-enable is asserted only during CPU reads, so no bus conflict occurs. A second strap selects the nametable arrangement: horizontal, vertical, or single-screen under control of the register.

The bank register captures the byte while the qualified write strobe is active. It commits the byte on the first clock edge after the strobe ends. All address and strobe outputs are combinational from the register and the live bus signals.

Top module: `cart_mapper`

## Requirements
- R1: A synchronous active-high reset clears the bank register to 0. After reset, with CPU A14 = 0, the program bank output reads 0 and the CHR bank output reads 0.
- R2: With CPU A14 = 0, `prg_bank` (ROM address lines 18..14) equals bank register bits 4:0.
- R3: With CPU A14 = 1, `prg_bank` is 5'b11111 (bank 31), whatever the register holds.
- R4: `chr_bank` (CHR RAM address lines 14..13) equals bank register bits 6:5 at all times.
- R5: The nametable page output depends on `mirror_mode`. Code 0 (horizontal) gives PPU A11. Code 1 (vertical) gives PPU A10. Codes 2 and 3 (single-screen) give bank register bit 7.
- R6: In locked mode (`flash_mode` = 0), `flash_we_n` stays 1 and `flash_oe_n` stays 0.
- R7: In locked mode, a CPU write with ROM select low loads the register with `cpu_data & rom_data`, for either value of A14.
- R8: In programmable mode (`flash_mode` = 1), a write with A14 = 1 loads the register with `cpu_data` exactly, ignoring `rom_data`.
- R9: In programmable mode, a write with A14 = 0 drives `flash_we_n` low while the strobe lasts and leaves the bank register unchanged.
- R10: In programmable mode, `flash_oe_n` is 0 only when ROM select is low and R/W is 1 (read). Otherwise it is 1.
- R11: The register keeps its old value while a qualified write strobe is still active. It takes the new value on the first clock edge at which the strobe is seen inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| flash_mode | input | 1 | Strap: 0 locked, 1 programmable |
| mirror_mode | input | 2 | Strap: 0 horizontal, 1 vertical, 2/3 single-screen |
| rom_sel_n | input | 1 | Active-low cartridge program space select |
| cpu_rw | input | 1 | 1 read, 0 write |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_data | input | 8 | Byte driven by the CPU |
| rom_data | input | 8 | Byte driven by the program ROM at that address |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_bank | output | 5 | Program ROM address lines 18..14 |
| chr_bank | output | 2 | CHR RAM address lines 14..13 |
| nt_page | output | 1 | Nametable RAM A10 |
| flash_we_n | output | 1 | Flash write-enable, active low |
| flash_oe_n | output | 1 | Flash output-enable, active low |

## Verification
A corrupted bank register shows at the ports on the next observation. A wrong bit 4..0 appears on `prg_bank` as soon as A14 is low, a wrong bit 6..5 appears on `chr_bank`, and a wrong bit 7 appears on `nt_page` under the single-screen strap. The bench therefore writes all 256 byte values in each mode and reads the three outputs back right after the commit edge. A missing or spurious AND with the ROM byte shows up in those same reads, because each write is paired with a ROM byte chosen to make the AND visible. A commit that happens one edge too early is caught by reading `chr_bank` while the strobe is still held.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MIR_HORIZ   = 2'd0,
        MIR_VERT    = 2'd1,
        MIR_SINGLE  = 2'd2,
        MIR_SINGLE2 = 2'd3
    } mirror_e;

    typedef struct packed {
        logic flash_mode;
        logic rom_sel_n;
        logic cpu_rw;
        logic cpu_a14;
    } cpu_bus_t;

    // Byte that the register captures: the ROM fights the CPU on the bus in locked mode.
    function automatic logic [DATA_W-1:0] bus_value(
        input logic              locked,
        input logic [DATA_W-1:0] cpu_b,
        input logic [DATA_W-1:0] rom_b
    );
        return locked ? (cpu_b & rom_b) : cpu_b;
    endfunction

    function automatic logic page_pick(
        input mirror_e m,
        input logic    a10,
        input logic    a11,
        input logic    reg_page
    );
        case (m)
            MIR_HORIZ: return a11;
            MIR_VERT:  return a10;
            default:   return reg_page;
        endcase
    endfunction

endpackage

// File: rtl/cm_strobe_dec.sv
module cm_strobe_dec
    import cart_mapper_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_bus_t bus,
    output logic     flash_we_n,
    output logic     flash_oe_n,
    output logic     reg_wr
);

    logic cyc_wr;
    logic cyc_rd;

    always_comb begin
        cyc_wr = !bus.rom_sel_n && !bus.cpu_rw;
        cyc_rd = !bus.rom_sel_n &&  bus.cpu_rw;
        if (bus.flash_mode) begin
            flash_we_n = !(cyc_wr && !bus.cpu_a14);
            flash_oe_n = !cyc_rd;
            reg_wr     = cyc_wr && bus.cpu_a14;
        end else begin
            flash_we_n = 1'b1;
            flash_oe_n = 1'b0;
            reg_wr     = cyc_wr;
        end
    end

    AST_LOCKED_PINS: assert property (@(posedge clk) disable iff (rst)
        !bus.flash_mode |-> (flash_we_n && !flash_oe_n)); // R6

    AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (bus.flash_mode && !flash_oe_n) |-> (bus.cpu_rw && !bus.rom_sel_n)); // R10

    AST_WE_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        !flash_we_n |-> (bus.flash_mode && !bus.cpu_a14 && !reg_wr)); // R9

endmodule

// File: rtl/cm_bank_reg.sv
module cm_bank_reg
    import cart_mapper_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              locked,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [DATA_W-1:0] rom_data,
    output logic [REG_W-1:0]  bank_q
);

    logic [DATA_W-1:0] bus_b;
    logic [REG_W-1:0]  held;
    logic              pending;

    assign bus_b = bus_value(locked, cpu_data, rom_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= '0;
            held    <= '0;
            pending <= 1'b0;
        end else if (reg_wr) begin
            held    <= bus_b[REG_W-1:0];
            pending <= 1'b1;
        end else if (pending) begin
            bank_q  <= held;
            pending <= 1'b0;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && $past(!reg_wr)) |=> $stable(bank_q)); // R11

    AST_HOLD_DURING_WR: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> $stable(bank_q) || $past(pending)); // R11

endmodule

// File: rtl/cm_addr_map.sv
module cm_addr_map
    import cart_mapper_pkg::*;
#(
    parameter int PRG_W = 5,
    parameter int CHR_W = 2,
    localparam int REG_W = PRG_W + CHR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] bank_q,
    input  logic             cpu_a14,
    input  mirror_e          mirror,
    input  logic             ppu_a10,
    input  logic             ppu_a11,
    output logic [PRG_W-1:0] prg_bank,
    output logic [CHR_W-1:0] chr_bank,
    output logic             nt_page
);

    localparam int CHR_LO = PRG_W;
    localparam int PAGE_B = PRG_W + CHR_W;

    genvar g;
    generate
        for (g = 0; g < PRG_W; g++) begin : g_prg_line
            assign prg_bank[g] = cpu_a14 | bank_q[g];
        end
    endgenerate

    assign chr_bank = bank_q[CHR_LO +: CHR_W];
    assign nt_page  = page_pick(mirror, ppu_a10, ppu_a11, bank_q[PAGE_B]);

    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (rst)
        cpu_a14 |-> (&prg_bank)); // R3

    AST_SWITCH_LOW: assert property (@(posedge clk) disable iff (rst)
        !cpu_a14 |-> (prg_bank == bank_q[PRG_W-1:0])); // R2

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int PRG_W = 5,
    parameter int CHR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flash_mode,
    input  logic [1:0]       mirror_mode,
    input  logic             rom_sel_n,
    input  logic             cpu_rw,
    input  logic             cpu_a14,
    input  logic [7:0]       cpu_data,
    input  logic [7:0]       rom_data,
    input  logic             ppu_a10,
    input  logic             ppu_a11,
    output logic [PRG_W-1:0] prg_bank,
    output logic [CHR_W-1:0] chr_bank,
    output logic             nt_page,
    output logic             flash_we_n,
    output logic             flash_oe_n
);

    localparam int REG_W = PRG_W + CHR_W + 1;

    cpu_bus_t         bus;
    logic             reg_wr;
    logic [REG_W-1:0] bank_q;

    assign bus = '{flash_mode: flash_mode, rom_sel_n: rom_sel_n,
                   cpu_rw: cpu_rw, cpu_a14: cpu_a14};

    cm_strobe_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .bus        (bus),
        .flash_we_n (flash_we_n),
        .flash_oe_n (flash_oe_n),
        .reg_wr     (reg_wr)
    );

    cm_bank_reg #(.REG_W(REG_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .locked   (!flash_mode),
        .cpu_data (cpu_data),
        .rom_data (rom_data),
        .bank_q   (bank_q)
    );

    cm_addr_map #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .bank_q   (bank_q),
        .cpu_a14  (cpu_a14),
        .mirror   (mirror_e'(mirror_mode)),
        .ppu_a10  (ppu_a10),
        .ppu_a11  (ppu_a11),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank),
        .nt_page  (nt_page)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (chr_bank == '0) && (cpu_a14 || prg_bank == '0)); // R1

endmodule

// File: tb/cart_mapper_tb.sv
`timescale 1ns/1ps
module cart_mapper_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flash_mode = 1'b0;
    logic [1:0] mirror_mode = 2'd2;
    logic       rom_sel_n = 1'b1;
    logic       cpu_rw = 1'b1;
    logic       cpu_a14 = 1'b0;
    logic [7:0] cpu_data = 8'h00;
    logic [7:0] rom_data = 8'hFF;
    logic       ppu_a10 = 1'b0;
    logic       ppu_a11 = 1'b0;
    logic [4:0] prg_bank;
    logic [1:0] chr_bank;
    logic       nt_page;
    logic       flash_we_n;
    logic       flash_oe_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cart_mapper dut_i (
        .clk(clk), .rst(rst), .flash_mode(flash_mode), .mirror_mode(mirror_mode),
        .rom_sel_n(rom_sel_n), .cpu_rw(cpu_rw), .cpu_a14(cpu_a14),
        .cpu_data(cpu_data), .rom_data(rom_data), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .nt_page(nt_page),
        .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; rom_sel_n = 1'b1; cpu_rw = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // Strobe held across two edges, released, then one more edge to commit.
    task automatic cpu_write(input logic a14, input logic [7:0] d, input logic [7:0] rd);
        @(negedge clk); cpu_a14 = a14; cpu_data = d; rom_data = rd; cpu_rw = 1'b0; rom_sel_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rom_sel_n = 1'b1; cpu_rw = 1'b1;
        @(negedge clk);
    endtask

    // Reads the register back through the address outputs.
    task automatic read_reg(input string req, input logic [7:0] exp);
        mirror_mode = 2'd2;
        cpu_a14 = 1'b0; #1;
        chk({req, " prg"}, prg_bank, exp[4:0]);
        chk({req, " chr"}, chr_bank, exp[6:5]);
        chk({req, " page"}, nt_page, exp[7]);
        cpu_a14 = 1'b1; #1;
        chk("R3 fixed bank", prg_bank, 31);
        cpu_a14 = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] last;
        do_reset();
        #1;
        chk("R1 prg after reset", prg_bank, 0);
        chk("R1 chr after reset", chr_bank, 0);

        // Locked mode: every byte, with an AND-revealing ROM byte.
        flash_mode = 1'b0;
        for (int v = 0; v < 256; v++) begin
            rd = 8'((v * 73 + 11) ^ 8'h5A);
            cpu_write(1'(v % 2), 8'(v), rd);
            read_reg("R7 R2 R4 locked AND", 8'(v) & rd);
            if (v % 64 == 0) begin
                chk("R6 we_n idle", flash_we_n, 1);
                chk("R6 oe_n idle", flash_oe_n, 0);
            end
        end
        @(negedge clk); cpu_rw = 1'b0; rom_sel_n = 1'b0; #1;
        chk("R6 we_n on write", flash_we_n, 1);
        chk("R6 oe_n on write", flash_oe_n, 0);
        @(negedge clk); rom_sel_n = 1'b1; cpu_rw = 1'b1; cpu_data = 8'h00; rom_data = 8'h00;
        @(negedge clk);

        // Programmable mode.
        flash_mode = 1'b1;
        do_reset();
        #1;
        chk("R1 prg after second reset", prg_bank, 0);
        for (int v = 0; v < 256; v++) begin
            cpu_write(1'b1, 8'(v), ~8'(v));
            read_reg("R8 R2 R4 no AND", 8'(v));
        end
        last = 8'hFF;
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); cpu_a14 = 1'b0; cpu_data = 8'(v * 17); rom_data = 8'h00;
            cpu_rw = 1'b0; rom_sel_n = 1'b0; #1;
            chk("R9 we_n low", flash_we_n, 0);
            chk("R10 oe_n high on write", flash_oe_n, 1);
            @(negedge clk); rom_sel_n = 1'b1; cpu_rw = 1'b1; #1;
            chk("R9 we_n released", flash_we_n, 1);
            @(negedge clk);
            read_reg("R9 register unchanged", last);
        end
        @(negedge clk); cpu_a14 = 1'b1; cpu_rw = 1'b0; rom_sel_n = 1'b0; #1;
        chk("R10 oe_n high upper write", flash_oe_n, 1);
        chk("R9 we_n high upper write", flash_we_n, 1);
        @(negedge clk); cpu_rw = 1'b1; #1;
        chk("R10 oe_n low on read", flash_oe_n, 0);
        @(negedge clk); rom_sel_n = 1'b1; #1;
        chk("R10 oe_n high idle", flash_oe_n, 1);
        // Register commit timing.
        @(negedge clk);
        cpu_write(1'b1, 8'h00, 8'h00);
        @(negedge clk); cpu_a14 = 1'b1; cpu_data = 8'hE0; cpu_rw = 1'b0; rom_sel_n = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        chk("R11 old chr while held", chr_bank, 0);
        rom_sel_n = 1'b1; cpu_rw = 1'b1; #1;
        chk("R11 old chr at release", chr_bank, 0);
        @(negedge clk); #1;
        chk("R11 new chr after edge", chr_bank, 3);

        // Nametable arrangements with both page values.
        for (int p = 0; p < 2; p++) begin
            cpu_write(1'b1, p[0] ? 8'h80 : 8'h00, 8'h00);
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < 4; a++) begin
                    mirror_mode = 2'(m); ppu_a10 = a[0]; ppu_a11 = a[1]; #1;
                    chk("R5 nametable page", nt_page,
                        (m == 0) ? a[1] : (m == 1) ? a[0] : p);
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule